// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block is the digital output-divider stage of a clock generator. It receives a reference clock and a second clock that stands in for a PLL output. A mode input picks which of the two clocks drives the divider. A 4-bit select code sets a division ratio of 1, 2, 4, 8, 16, 32 or 64. The mapping from code to ratio is deliberately non-monotonic.

The divided clock leaves on a main pair and on a feedback pair. Each pair has a true output and its complement, and both pairs carry the same waveform. An active-high master reset clears the divider at once and forces every true output low. Reset release is synchronised to the selected clock, so the first output period after reset is always complete.

In divide-by-one the selected clock is passed through an enable that is registered on the falling edge, so the output carries no partial pulse. A new select code is picked up only where the output would rise, so a change in ratio never produces a runt pulse.

Top module: `pow2_clk_div`

## Requirements
- R1: The select code sets the ratio N between output period and selected-clock period:
  - N = 1 for codes 13 and 15.
  - N = 2 for codes 10, 11 and 14.
  - N = 4 for codes 0, 1, 2 and 12.
  - N = 8 for codes 3, 4 and 5.
  - N = 16 for codes 6 and 7.
  - N = 32 for code 8.
  - N = 64 for code 9.
- R2: With `mode_pll` low the divider runs from `ref_clk`; with `mode_pll` high it runs from `pll_clk`. The unselected clock has no effect on the output period.
- R3: While `mrst` is high, `out_p` and `fb_p` are low and `out_n` and `fb_n` are high. This takes effect without waiting for a clock edge.
- R4: After `mrst` falls, the first rising edge of `out_p` coincides with the third rising edge of the selected clock.
- R5: For an even ratio N, each output period lasts N selected-clock periods, and the output is high for exactly N/2 of them.
- R6: `out_n` is always the inverse of `out_p`, `fb_p` always equals `out_p`, and `fb_n` always equals `out_n`.
- R7: For ratio 1, `out_p` rises with each rising edge of the selected clock and falls with each falling edge of it.
- R8: When the select code changes, the output period in progress finishes at the old ratio. The new ratio applies from the next rising edge of `out_p` onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| pll_clk | input | 1 | Clock standing in for the PLL output |
| mode_pll | input | 1 | Source select: 0 = reference clock, 1 = PLL clock |
| div_sel | input | 4 | Ratio select code |
| mrst | input | 1 | Master reset, active high |
| out_p | output | 1 | Divided clock, true |
| out_n | output | 1 | Divided clock, complement |
| fb_p | output | 1 | Feedback copy, true |
| fb_n | output | 1 | Feedback copy, complement |

## Verification
Each result has a fixed due time, counted in selected-clock rising edges:
- The reset levels are due half a nanosecond after `mrst` rises, with no clock edge needed.
- The first output rise is due on the third selected-clock rising edge after release: two edges for the synchroniser and one for the divider register.
- After a select change, one period at the old ratio is due first, then periods at the new ratio.

The monitor timestamps every rising and falling edge of `out_p`. At each rise it pops one expected (period, high time) pair and compares it. The driver pushes these pairs only after the first two rises following release, so every compared period starts on a real output edge. All levels are sampled half a nanosecond after an edge, never on one.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  localparam int SEL_W  = 4;                     // width of the ratio select code
  localparam int MAX_LG = 6;                     // largest ratio is 2**MAX_LG
  localparam int LG_W   = $clog2(MAX_LG + 1);    // width of a log2 ratio
  localparam int CNT_W  = (MAX_LG > 1) ? MAX_LG - 1 : 1;  // half-period counter width

  // Turns a select code into log2 of the division ratio.
  function automatic logic [LG_W-1:0] sel_to_lg(input logic [SEL_W-1:0] code);
    logic [LG_W-1:0] lg;
    case (code)
      4'd13, 4'd15:               lg = LG_W'(0);
      4'd10, 4'd11, 4'd14:        lg = LG_W'(1);
      4'd0,  4'd1,  4'd2, 4'd12:  lg = LG_W'(2);
      4'd3,  4'd4,  4'd5:         lg = LG_W'(3);
      4'd6,  4'd7:                lg = LG_W'(4);
      4'd8:                       lg = LG_W'(5);
      4'd9:                       lg = LG_W'(6);
      default:                    lg = LG_W'(0);
    endcase
    return lg;
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_out
);

  logic [STAGES-1:0] chain;

  // Assert at once; release only after STAGES clock edges.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '1;
    else      chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain[STAGES-1];

  AST_REL_STAYS: assert property (@(posedge clk) disable iff (arst)
    !rst_out |=> !rst_out);  // R4

endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int LGW  = LG_W,
  parameter int CNTW = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LGW-1:0] lg_next,
  output logic           div_out
);

  logic [LGW-1:0]  act_lg;   // ratio currently in force, log2
  logic [CNTW-1:0] cnt;      // position inside the current half period
  logic [CNTW-1:0] half_m1;  // last count value of a half period
  logic            div_q;    // registered divided clock
  logic            fresh;    // first edge after reset still to come
  logic            pass_en;  // enable for the divide-by-one path
  logic            at_term;

  always_comb begin
    if (act_lg == '0) half_m1 = '0;
    else half_m1 = CNTW'((32'd1 << (act_lg - LGW'(1))) - 32'd1);
  end

  assign at_term = (cnt == half_m1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act_lg <= '0;
      cnt    <= '0;
      div_q  <= 1'b0;
      fresh  <= 1'b1;
    end else if (fresh || act_lg == '0) begin
      // Start a period: every edge is a rising point in ratio one.
      act_lg <= lg_next;
      cnt    <= '0;
      div_q  <= 1'b1;
      fresh  <= 1'b0;
    end else if (at_term) begin
      cnt <= '0;
      if (!div_q) begin
        // Rising point: the only place a new ratio is taken.
        act_lg <= lg_next;
        div_q  <= 1'b1;
      end else begin
        div_q <= 1'b0;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Enable changes only while the clock is low, so the gated path cannot glitch.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) pass_en <= 1'b0;
    else     pass_en <= 1'b1;
  end

  assign div_out = (act_lg == '0) ? (clk & pass_en) : div_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (act_lg != '0) |-> (cnt <= half_m1));  // R5
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fresh && act_lg != '0 && !at_term) |=> $stable(div_q));  // R5
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fresh && act_lg != '0 && !(at_term && !div_q)) |=> $stable(act_lg));  // R8

endmodule

// File: rtl/pow2_clk_div.sv
`timescale 1ns/1ps
module pow2_clk_div
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             pll_clk,
  input  logic             mode_pll,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             mrst,
  output logic             out_p,
  output logic             out_n,
  output logic             fb_p,
  output logic             fb_n
);

  logic clk_sel;
  logic rst_s;
  logic div_o;

  // Source choice; mode_pll is meant to change only while mrst is high.
  assign clk_sel = mode_pll ? pll_clk : ref_clk;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk_sel),
    .arst    (mrst),
    .rst_out (rst_s)
  );

  clkdiv_core #(.LGW(LG_W), .CNTW(CNT_W)) u_core (
    .clk     (clk_sel),
    .rst     (rst_s),
    .lg_next (sel_to_lg(div_sel)),
    .div_out (div_o)
  );

  assign out_p = div_o;
  assign out_n = ~div_o;
  assign fb_p  = div_o;
  assign fb_n  = ~div_o;

  always @(posedge clk_sel) begin
    if (mrst) begin
      AST_RST_OUT: assert (!out_p && out_n && !fb_p && fb_n);  // R3
    end
  end

endmodule

// File: tb/sim_pow2_clk_div.sv
`timescale 1ns/1ps
module sim_pow2_clk_div;

  logic       ref_clk = 1'b0;
  logic       pll_clk = 1'b0;
  logic       mode_pll = 1'b0;
  logic [3:0] div_sel = 4'd0;
  logic       mrst = 1'b1;
  logic       out_p, out_n, fb_p, fb_n;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    armed = 1'b0;
  bit    have_prev = 1'b0;
  real   last_rise = 0.0;
  real   last_fall = 0.0;
  real   q_per[$];
  real   q_hi[$];
  string q_tag[$];

  pow2_clk_div u0 (
    .ref_clk (ref_clk), .pll_clk (pll_clk), .mode_pll (mode_pll),
    .div_sel (div_sel), .mrst (mrst),
    .out_p (out_p), .out_n (out_n), .fb_p (fb_p), .fb_n (fb_n)
  );

  // Reference clock: 250 MHz, rising edges at 2, 6, 10 ns and so on.
  initial forever #2 ref_clk = ~ref_clk;
  // PLL stand-in clock: 6 ns period, rising edges at 3, 9, 15 ns and so on.
  initial forever #3 pll_clk = ~pll_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0.3f expected %0.3f at %0t",
               req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_ratio(input logic [3:0] code);
    case (code)
      4'd13, 4'd15:              return 1;
      4'd10, 4'd11, 4'd14:       return 2;
      4'd0, 4'd1, 4'd2, 4'd12:   return 4;
      4'd3, 4'd4, 4'd5:          return 8;
      4'd6, 4'd7:                return 16;
      4'd8:                      return 32;
      default:                   return 64;
    endcase
  endfunction

  task automatic push_item(input int n, input real t, input string tag);
    q_per.push_back(n * t);
    q_hi.push_back((n == 1) ? t / 2.0 : n * t / 2.0);
    q_tag.push_back(tag);
  endtask

  // Monitor: at each rise, compare the period that just ended.
  always @(posedge out_p) begin
    real now;
    now = $realtime;
    if (armed && have_prev && q_per.size() > 0) begin
      real ep, eh;
      string tg;
      ep = q_per.pop_front();
      eh = q_hi.pop_front();
      tg = q_tag.pop_front();
      chk(((now - last_rise) - ep < 0.01) && (ep - (now - last_rise) < 0.01),
          tg, "period", now - last_rise, ep);
      chk(((last_fall - last_rise) - eh < 0.01) && (eh - (last_fall - last_rise) < 0.01),
          tg, "high time", last_fall - last_rise, eh);
    end
    last_rise = now;
    have_prev = 1'b1;
  end

  always @(negedge out_p) last_fall = $realtime;

  task automatic chk_reset_levels(input string what);
    chk(!out_p && out_n && !fb_p && fb_n, "R3", what,
        real'(out_p) + 2.0 * real'(fb_p), 0.0);
    chk(out_n && fb_n, "R3", {what, " complements"},
        real'(out_n) + real'(fb_n), 2.0);
  endtask

  // Reset, configure, release, check the first rise, then queue k periods.
  task automatic run_cfg(input bit m, input logic [3:0] code, input int k);
    real tp, off, tr, t1, exp1;
    int  n;
    tp = m ? 6.0 : 4.0;
    off = m ? 3.0 : 2.0;
    n = exp_ratio(code);
    armed = 1'b0;
    mrst = 1'b1;
    #20;
    mode_pll = m;
    div_sel = code;
    #20;
    chk_reset_levels("reset levels");
    have_prev = 1'b0;
    tr = $realtime;
    mrst = 1'b0;
    @(posedge out_p);
    t1 = $realtime;
    exp1 = off + ($floor((tr - off) / tp) + 1.0) * tp + 2.0 * tp;
    chk((t1 - exp1 < 0.01) && (exp1 - t1 < 0.01), "R4", "first rise time", t1, exp1);
    @(posedge out_p);
    #0.5;
    chk(out_p && !out_n && fb_p && !fb_n, "R6", "pair levels while high",
        real'(out_n) + real'(!fb_p) + real'(fb_n), 0.0);
    for (int i = 0; i < k; i++)
      push_item(n, tp, (n == 1) ? "R7" : (m ? "R2" : "R1/R5"));
    armed = 1'b1;
    repeat (k) @(posedge out_p);
    #0.5;
    chk(q_per.size() == 0, "R1", "all periods seen", real'(q_per.size()), 0.0);
  endtask

  // Change the code just after a rise: finish old period, then new ratio.
  task automatic change_sel(input logic [3:0] code, input int old_n, input int k);
    @(posedge out_p);
    #0.5;
    div_sel = code;
    push_item(old_n, 4.0, "R8");
    for (int i = 0; i < k; i++) push_item(exp_ratio(code), 4.0, "R8");
    repeat (k + 1) @(posedge out_p);
    #0.5;
    chk(q_per.size() == 0, "R8", "periods after change", real'(q_per.size()), 0.0);
  endtask

  initial begin
    #0.5;
    #10;
    chk_reset_levels("initial reset");
    // R1, R5, R7: every code from the reference clock
    for (int c = 0; c < 16; c++) run_cfg(1'b0, c[3:0], 2);
    // R2: same codes from the PLL clock give different periods
    run_cfg(1'b1, 4'd12, 2);
    run_cfg(1'b1, 4'd15, 2);
    run_cfg(1'b1, 4'd8, 1);
    // R8: ratio changes, including into and out of ratio one
    run_cfg(1'b0, 4'd0, 1);
    change_sel(4'd4, 4, 2);
    change_sel(4'd13, 8, 3);
    change_sel(4'd10, 1, 2);
    change_sel(4'd9, 2, 1);
    // R3: reset raised while the output is high acts without a clock edge
    run_cfg(1'b0, 4'd3, 1);
    @(posedge out_p);
    #0.5;
    mrst = 1'b1;
    #1;
    chk_reset_levels("async reset mid-period");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule